// File: doc/BRIEF.md
# Bus Request Client with Select-Acknowledge Handshake

This block is the requesting side of a priority arbitration scheme for one attached device. The device raises and withdraws request classes (several interrupt levels and one non-processor transfer class). The client drives its pending requests onto shared request lines, which are wired-OR with other devices. It watches the daisy-chained grant inputs and passes every grant it did not ask for straight through to the next slot.

When a grant meets one of its own pending requests, the client claims it. In a single cycle it asserts the select-acknowledge line (SACK), withdraws the granted request line and latches the won mask. The latched mask then waits until the current bus master releases the shared bus-busy line. After that the client emits a one-cycle strobe with the won mask, so a data or interrupt cycle engine can start. That engine later releases SACK. An init pulse aborts everything.

Top module: `bus_req_client`

## Requirements
- R1: Bit i of every mask (requests, grants, won mask) belongs to request class i. A bit set on `req_set_i` appears on `bus_req_o` at the next clock edge and stays until it is granted, cancelled or cleared by init.
- R2: A bit on `req_cancel_i` is absent from `bus_req_o` after the next edge. Cancel wins over a set of the same bit in the same cycle.
- R3: `grant_out_o` equals `grant_in_i` combinationally for every class not currently requested.
- R4: When the client is waiting for a grant and `grant_in_i` hits a pending request, at the next edge `sack_o` is high and the granted bits are gone from `bus_req_o`, in that same cycle.
- R5: While a won mask is latched and `bbsy_i` is high, `won_valid_o` stays low and the latched mask is held.
- R6: At the first edge with `bbsy_i` low while a mask is latched, `won_valid_o` goes high for exactly one cycle with `won_mask_o` equal to the latched mask. The client then waits for grants again.
- R7: `init_i` clears the pending requests, `sack_o`, the latched mask and the strobe at the next edge. A mask latched before init is never reported.
- R8: `sack_o` stays high after a grant until `sack_release_i` is seen, and is low after that edge.
- R9: Requests set while a mask is latched appear on `bus_req_o` and do not change the won mask that is later reported.
- R10: A grant arriving in the same cycle as a cancel of its class is forwarded on `grant_out_o` and is not claimed: no SACK and no strobe follow.
- R11: While a mask is latched, a grant for another pending class is neither claimed nor forwarded, and that request stays on `bus_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Synchronous bus init pulse |
| req_set_i | input | NUM_CLASSES | Request classes to add |
| req_cancel_i | input | NUM_CLASSES | Request classes to withdraw |
| grant_in_i | input | NUM_CLASSES | Grant lines from the upstream slot |
| bbsy_i | input | 1 | Shared bus-busy line |
| sack_release_i | input | 1 | Cycle engine drops SACK |
| bus_req_o | output | NUM_CLASSES | Request lines onto the shared bus |
| grant_out_o | output | NUM_CLASSES | Grant lines to the downstream slot |
| sack_o | output | 1 | Select acknowledge |
| won_valid_o | output | 1 | One-cycle strobe: a grant was won and the bus is free |
| won_mask_o | output | NUM_CLASSES | Classes won, valid with the strobe |

## Verification
The assertions assume that `init_i` and `rst_ni` do the clearing and that grant inputs are steady within a cycle. They also assume the upstream arbiter raises a grant only for classes that are actually requested on the bus. The stimulus drives every input on the falling clock edge. It raises a grant only after the matching request is visible on `bus_req_o`, apart from deliberately unrequested pass-through grants. `bbsy_i` is held high across the wait state, to exercise the held latch, before it is lowered.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int unsigned BRC_CLASSES = 5;  // four interrupt levels plus one transfer class
endpackage

// File: rtl/brc_req_reg.sv
module brc_req_reg #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] cancel_i,
  input  logic [N-1:0] take_i,
  output logic [N-1:0] req_o
);
  logic [N-1:0] req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     req_q <= '0;
    else if (init_i) req_q <= '0;
    else             req_q <= ((req_q & ~take_i) | set_i) & ~cancel_i;
  end

  assign req_o = req_q;

  // R2
  cancel_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cancel_i) |=> ((req_o & $past(cancel_i)) == '0));
  // R1
  set_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i) |=> ((req_o & $past(set_i & ~cancel_i)) == $past(set_i & ~cancel_i)));
  // R4
  take_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|take_i) |=> ((req_o & $past(take_i & ~set_i)) == '0));
endmodule

// File: rtl/brc_grant_pass.sv
module brc_grant_pass #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] grant_i,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] cancel_i,
  input  logic         idle_i,
  output logic [N-1:0] grant_o,
  output logic [N-1:0] hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_cls
    logic own;
    assign own        = req_i[i] & ~cancel_i[i];  // a class cancelled this cycle is not ours
    assign grant_o[i] = grant_i[i] & ~own;
    assign hit_o[i]   = grant_i[i] & own & idle_i;
  end
endmodule

// File: rtl/brc_grant_seq.sv
module brc_grant_seq #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic [N-1:0] hit_i,
  input  logic         bbsy_i,
  input  logic         sack_release_i,
  output logic         idle_o,
  output logic         sack_o,
  output logic         won_valid_o,
  output logic [N-1:0] won_mask_o
);
  logic [N-1:0] lat_q;
  logic         sack_q, wv_q;
  logic [N-1:0] wm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0; sack_q <= 1'b0; wv_q <= 1'b0; wm_q <= '0;
    end else if (init_i) begin
      lat_q <= '0; sack_q <= 1'b0; wv_q <= 1'b0; wm_q <= '0;
    end else begin
      wv_q <= 1'b0;
      if (sack_release_i) sack_q <= 1'b0;
      if (|hit_i) begin
        lat_q  <= hit_i;
        sack_q <= 1'b1;
      end else if (lat_q != '0 && !bbsy_i) begin
        wv_q  <= 1'b1;
        wm_q  <= lat_q;
        lat_q <= '0;
      end
    end
  end

  assign idle_o      = (lat_q == '0);
  assign sack_o      = sack_q;
  assign won_valid_o = wv_q;
  assign won_mask_o  = wm_q;

  // R4
  claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_i && !init_i) |=> (sack_o && lat_q == $past(hit_i)));
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q != '0 && bbsy_i && !init_i) |=> (!won_valid_o && $stable(lat_q)));
  // R6
  strobe_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    won_valid_o |=> !won_valid_o);
  // R6
  strobe_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    won_valid_o |-> (!$past(bbsy_i) && won_mask_o != '0));
  // R7
  init_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (!sack_o && !won_valid_o && idle_o));
  // R8
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sack_release_i && !(|hit_i)) |=> !sack_o);
endmodule

// File: rtl/bus_req_client.sv
module bus_req_client
  import brc_pkg::*;
#(
  parameter int unsigned NUM_CLASSES = BRC_CLASSES
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   init_i,
  input  logic [NUM_CLASSES-1:0] req_set_i,
  input  logic [NUM_CLASSES-1:0] req_cancel_i,
  input  logic [NUM_CLASSES-1:0] grant_in_i,
  input  logic                   bbsy_i,
  input  logic                   sack_release_i,
  output logic [NUM_CLASSES-1:0] bus_req_o,
  output logic [NUM_CLASSES-1:0] grant_out_o,
  output logic                   sack_o,
  output logic                   won_valid_o,
  output logic [NUM_CLASSES-1:0] won_mask_o
);
  localparam int unsigned N = NUM_CLASSES;

  logic [N-1:0] req_w, hit_w;
  logic         idle_w;

  brc_req_reg #(.N(N)) u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i),
    .set_i(req_set_i), .cancel_i(req_cancel_i), .take_i(hit_w), .req_o(req_w)
  );

  brc_grant_pass #(.N(N)) u_pass (
    .grant_i(grant_in_i), .req_i(req_w), .cancel_i(req_cancel_i),
    .idle_i(idle_w), .grant_o(grant_out_o), .hit_o(hit_w)
  );

  brc_grant_seq #(.N(N)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .hit_i(hit_w),
    .bbsy_i(bbsy_i), .sack_release_i(sack_release_i), .idle_o(idle_w),
    .sack_o(sack_o), .won_valid_o(won_valid_o), .won_mask_o(won_mask_o)
  );

  assign bus_req_o = req_w;

  // R11
  no_claim_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_w && !init_i) |=> ((bus_req_o & $past(req_w & grant_in_i & ~req_cancel_i))
                              == $past(req_w & grant_in_i & ~req_cancel_i)));
  // R7
  init_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (bus_req_o == '0));
endmodule

// File: tb/bus_req_client_tb_top.sv
module bus_req_client_tb_top;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         init = 1'b0, bbsy = 1'b0, rel = 1'b0;
  logic [N-1:0] set = '0, cancel = '0, gin = '0;
  logic [N-1:0] breq, gout, wmask;
  logic         sack, wvalid;

  int checks = 0, errors = 0;
  logic [N-1:0] exp_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  bus_req_client #(.NUM_CLASSES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .req_set_i(set),
    .req_cancel_i(cancel), .grant_in_i(gin), .bbsy_i(bbsy),
    .sack_release_i(rel), .bus_req_o(breq), .grant_out_o(gout),
    .sack_o(sack), .won_valid_o(wvalid), .won_mask_o(wmask)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic push_won(input logic [N-1:0] m);
    exp_q.push_back(m);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // monitor: every strobe must match the oldest expected won mask (R6, R9)
  always @(negedge clk) begin
    if (rst_n && wvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6: actual strobe mask %0h expected no strobe", wmask);
      end else begin
        logic [N-1:0] e;
        e = exp_q.pop_front();
        if (wmask !== e) begin
          errors++;
          $display("FAIL R6: actual won mask %0h expected %0h", wmask, e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // reset state
    chk("R7 reset req", breq, 0);
    chk("R7 reset sack", sack, 0);
    chk("R7 reset strobe", wvalid, 0);

    // R1 set transfer class and level 1
    set = 5'b10010; step(); set = '0;
    chk("R1 set", breq, 5'b10010);

    // R3 pass-through of unrequested grants
    gin = 5'b00101; #1;
    chk("R3 forward", gout, 5'b00101);
    step(); gin = '0;
    chk("R3 no claim", sack, 0);

    // R2 cancel level 1, set+cancel level 3
    set = 5'b01000; cancel = 5'b01010; step(); set = '0; cancel = '0;
    chk("R2 cancel wins", breq, 5'b10000);

    // R4 grant transfer class while bus busy
    bbsy = 1'b1; push_won(5'b10000);
    gin = 5'b10000; #1;
    chk("R3 own grant not forwarded", gout, 0);
    step(); gin = '0;
    chk("R4 sack", sack, 1);
    chk("R4 req dropped", breq, 0);

    // R9 request added while latched
    set = 5'b00001; step(); set = '0;
    chk("R9 new req", breq, 5'b00001);

    // R11 grant for pending class while latched
    gin = 5'b00001; #1;
    chk("R11 not forwarded", gout, 0);
    step(); gin = '0;
    chk("R11 req kept", breq, 5'b00001);

    // R5 hold while bus busy
    repeat (3) step();
    chk("R5 no strobe", wvalid, 0);
    chk("R5 sack held", sack, 1);

    // R6 bus free
    bbsy = 1'b0; step();
    chk("R6 strobe", wvalid, 1);
    chk("R9 mask unchanged", wmask, 5'b10000);
    step();
    chk("R6 one cycle", wvalid, 0);
    chk("R8 sack until release", sack, 1);

    // R8 release
    rel = 1'b1; step(); rel = 1'b0;
    chk("R8 released", sack, 0);

    // R4/R6 fast path, bus already free
    push_won(5'b00001);
    gin = 5'b00001; step(); gin = '0;
    chk("R4 sack fast", sack, 1);
    chk("R4 req dropped fast", breq, 0);
    step();
    chk("R6 strobe fast", wvalid, 1);
    rel = 1'b1; step(); rel = 1'b0;
    chk("R8 released again", sack, 0);

    // R10 cancel with grant in the same cycle
    set = 5'b00100; step(); set = '0;
    gin = 5'b00100; cancel = 5'b00100; #1;
    chk("R10 forwarded", gout, 5'b00100);
    step(); gin = '0; cancel = '0;
    chk("R10 no sack", sack, 0);
    chk("R10 req gone", breq, 0);
    step();
    chk("R10 no strobe", wvalid, 0);

    // R7 init aborts a latched grant
    bbsy = 1'b1;
    set = 5'b01010; step(); set = '0;
    gin = 5'b01000; step(); gin = '0;
    chk("R7 pre sack", sack, 1);
    init = 1'b1; step(); init = 1'b0;
    chk("R7 req cleared", breq, 0);
    chk("R7 sack cleared", sack, 0);
    bbsy = 1'b0;
    repeat (3) step();
    chk("R7 no strobe", wvalid, 0);

    chk("R6 scoreboard empty", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule